// File: doc/BRIEF.md
# Stall-Holding Write-First Register File

A synchronous register file for the decode stage of a pipelined processor. It has one write port and one read port with a single cycle of latency. A build parameter adds a second read port, which has its own address and data. When a read and a write hit the same entry on the same clock edge, the read returns the data being written. This is write-first, transparent behaviour.

A decode-stall input freezes every read output at the value it showed before the stall. The read address register still loads on every edge, including stalled ones. For this reason the hold comes from saving the last output, not from gating the address. When the stall ends, the outputs show the entry at the most recently captured address, with the write-first bypass applied. Writes are never blocked by a stall. The stored contents are not reset.

Top module: `hold_regfile`

## Requirements
- R1: When `we_i` is high at a rising edge, `wdata_i` is stored at entry `waddr_i`, and a later read of that entry returns it.
- R2: With stall low at a rising edge, the read output shows the contents of the entry whose address was applied at that edge, from just after that edge until the next edge.
- R3: If a write and an unstalled read use the same address at the same edge, the read output after that edge equals the written data.
- R4: If `stall_i` is high at a rising edge, every read output after that edge equals its value before that edge.
- R5: A write with `stall_i` high is still stored, and a read after the stall returns it.
- R6: A write during a stall to the entry behind a held output leaves that output unchanged until the stall is released.
- R7: On the first edge with `stall_i` low after a stall, each output takes the entry at the address applied at that edge, including a write made at that same edge.
- R8: With `SECOND_READ` = 1 (the default), port B reads independently of port A and follows R2, R3, R4, R6 and R7.
- R9: While `rst_ni` is low, both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset of the control and output state, active low |
| stall_i | input | 1 | Decode stall; holds both read outputs |
| we_i | input | 1 | Write enable |
| waddr_i | input | AW | Write address |
| wdata_i | input | DATA_W | Write data |
| raddr_a_i | input | AW | Port A read address |
| rdata_a_o | output | DATA_W | Port A read data |
| raddr_b_i | input | AW | Port B read address |
| rdata_b_o | output | DATA_W | Port B read data (zero if `SECOND_READ` = 0) |

## Verification
The assertions assume that the write and read addresses stay below DEPTH, that inputs settle between clock edges, and that the read outputs before the first edge after reset are the reset zeros. The bench drives every input on the falling edge. It draws addresses only from the populated range, and it often narrows them to a few entries so that write and read addresses collide on the same edge. Stall bursts are randomized in length, and some writes land on the held entries while a stall is active.

// File: rtl/hold_rf_pkg.sv
package hold_rf_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_DEPTH  = 32;

  function automatic int unsigned rd_ports(input bit second);
    return second ? 2 : 1;
  endfunction
endpackage

// File: rtl/rf_storage.sv
// Storage array with a read-first registered read per port; bypass is added outside.
module rf_storage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned N_RD   = 2,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_RD-1:0][AW-1:0]     raddr_i,
  output logic [N_RD-1:0][DATA_W-1:0] rd_q_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q_o[p] <= '0;
      else if (32'(raddr_i[p]) < DEPTH) rd_q_o[p] <= mem_q[raddr_i[p]];
      else rd_q_o[p] <= '0;
    end
  end
endmodule

// File: rtl/rf_bypass.sv
// Same-edge write forwarding for one read port.
module rf_bypass #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  input  logic [DATA_W-1:0] ram_i,
  output logic [DATA_W-1:0] live_o
);
  logic              hit_q;
  logic [DATA_W-1:0] fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      fwd_q <= '0;
    end else begin
      hit_q <= we_i && (waddr_i == raddr_i);
      if (we_i && (waddr_i == raddr_i)) fwd_q <= wdata_i;
    end
  end

  assign live_o = hit_q ? fwd_q : ram_i;
endmodule

// File: rtl/rf_hold.sv
// Keeps the pre-stall output while the address path keeps loading.
module rf_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] live_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              stall_q;
  logic [DATA_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q <= 1'b0;
      held_q  <= '0;
    end else begin
      stall_q <= stall_i;
      // capture only on stall entry; later stalled edges keep it
      if (stall_i && !stall_q) held_q <= live_i;
    end
  end

  assign rdata_o = stall_q ? held_q : live_i;
endmodule

// File: rtl/hold_regfile.sv
module hold_regfile
  import hold_rf_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned DEPTH       = DEF_DEPTH,
  parameter bit          SECOND_READ = 1'b1,
  localparam int unsigned AW         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned N_RD = rd_ports(SECOND_READ);

  logic [N_RD-1:0][AW-1:0]     raddr;
  logic [N_RD-1:0][DATA_W-1:0] ram_rd;
  logic [N_RD-1:0][DATA_W-1:0] live;
  logic [N_RD-1:0][DATA_W-1:0] rdata;

  assign raddr[0]  = raddr_a_i;
  assign rdata_a_o = rdata[0];

  if (N_RD > 1) begin : g_port_b
    assign raddr[1]  = raddr_b_i;
    assign rdata_b_o = rdata[1];
  end else begin : g_no_port_b
    assign rdata_b_o = '0;
  end

  rf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .N_RD(N_RD)) u_storage (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i,
    .raddr_i (raddr),
    .rd_q_o  (ram_rd)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    rf_bypass #(.DATA_W(DATA_W), .AW(AW)) u_bypass (
      .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i,
      .raddr_i (raddr[p]),
      .ram_i   (ram_rd[p]),
      .live_o  (live[p])
    );
    rf_hold #(.DATA_W(DATA_W)) u_hold (
      .clk_i, .rst_ni, .stall_i,
      .live_i  (live[p]),
      .rdata_o (rdata[p])
    );
  end
endmodule

// File: rtl/hold_regfile_chk.sv
module hold_regfile_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH       = 32,
  parameter bit          SECOND_READ = 1'b1,
  localparam int unsigned AW         = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              we_i,
  input logic [AW-1:0]     waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [AW-1:0]     raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [AW-1:0]     raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o
);
  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (rdata_a_o == '0 && rdata_b_o == '0); // R9
  end

  AST_HOLD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(rdata_a_o)); // R4

  AST_WRITE_FIRST_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !stall_i && waddr_i == raddr_a_i) |=> (rdata_a_o == $past(wdata_i))); // R3

  if (SECOND_READ) begin : g_b
    AST_HOLD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |=> $stable(rdata_b_o)); // R8

    AST_WRITE_FIRST_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !stall_i && waddr_i == raddr_b_i) |=> (rdata_b_o == $past(wdata_i))); // R8
  end
endmodule

bind hold_regfile hold_regfile_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .SECOND_READ(SECOND_READ)
) u_chk (.*);

// File: tb/hold_regfile_bench.sv
`timescale 1ns/1ps
module hold_regfile_bench;
  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, we = 1'b0;
  logic [AW-1:0] waddr = '0, ra = '0, rb = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_a, rdata_b;

  int n_run = 0, n_fail = 0;

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  bit            ref_ok  [DEPTH];
  logic [DW-1:0] exp_a = '0, exp_b = '0;
  bit            ok_a = 1'b1, ok_b = 1'b1;

  always #2 clk = ~clk;

  hold_regfile u_hold_regfile (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .we_i(we),
    .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(rdata_a),
    .raddr_b_i(rb), .rdata_b_o(rdata_b)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input bit s, input bit w, input int wa,
                      input logic [DW-1:0] wd, input int a, input int b);
    stall = s; we = w; waddr = AW'(wa); wdata = wd; ra = AW'(a); rb = AW'(b);
    @(posedge clk);
    if (!s) begin
      if (w && wa == a) begin exp_a = wd; ok_a = 1'b1; end
      else begin exp_a = ref_mem[a]; ok_a = ref_ok[a]; end
      if (w && wa == b) begin exp_b = wd; ok_b = 1'b1; end
      else begin exp_b = ref_mem[b]; ok_b = ref_ok[b]; end
    end
    if (w) begin ref_mem[wa] = wd; ref_ok[wa] = 1'b1; end
    @(negedge clk);
    if (ok_a) check({tag, " port A"}, rdata_a, exp_a);
    if (ok_b) check({tag, " port B R8"}, rdata_b, exp_b);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; ref_ok[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R9 reset A", rdata_a, '0);
    check("R9 reset B", rdata_b, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill, reading the previous entry (R1, R2)
    for (int i = 0; i < DEPTH; i++)
      step("R1", 0, 1, i, 32'hA5000000 + i * 32'h01010101, (i + DEPTH - 1) % DEPTH, i);
    for (int i = 0; i < 6; i++) step("R2", 0, 0, 0, '0, i * 5, 31 - i);

    // same-edge collisions on both ports
    step("R3", 0, 1, 5, 32'hDEADBEEF, 5, 5);
    step("R3", 0, 1, 6, 32'h12345678, 6, 7);
    step("R3", 0, 1, 8, 32'hCAFEF00D, 9, 8);

    // stall: hold while address and held entry change
    step("R2", 0, 0, 0, '0, 7, 11);
    step("R4", 1, 0, 0, '0, 9, 12);
    step("R6", 1, 1, 7, 32'h77777777, 9, 11);
    step("R5", 1, 1, 9, 32'h99999999, 3, 12);
    step("R6", 1, 1, 11, 32'hBBBBBBBB, 9, 11);
    step("R7", 0, 0, 0, '0, 9, 11);
    step("R5", 0, 0, 0, '0, 7, 9);

    // release edge with collision
    step("R4", 1, 0, 0, '0, 1, 2);
    step("R7", 0, 1, 2, 32'h0BADC0DE, 2, 2);

    // random traffic with frequent collisions and stall bursts
    for (int n = 0; n < 4000; n++) begin
      bit s = ($urandom_range(0, 9) < 3);
      bit w = ($urandom_range(0, 1) == 1);
      bit narrow = ($urandom_range(0, 1) == 1);
      int wa = narrow ? $urandom_range(0, 3) : $urandom_range(0, DEPTH - 1);
      int a  = narrow ? $urandom_range(0, 3) : $urandom_range(0, DEPTH - 1);
      int b  = narrow ? $urandom_range(0, 3) : $urandom_range(0, DEPTH - 1);
      step(s ? "R4 rand" : "R3 rand", s, w, wa, $urandom, a, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule